// File: doc/BRIEF.md
# Supply Lockout Timing Supervisor

This block sits between the digitised supply comparators of a half-bridge gate driver and its two output stages. It watches two flags for the floating high-side supply: one that says the supply is under the trip level, and one that says it is above the higher release level. It also watches a power-on-reset flag for the low-side supply. From these it decides, on every clock, whether the high-side command, the low-side command, or both may reach the output stage.

A high-side undervoltage is declared only after the under-trip flag has been seen on `FILT_CYCLES` consecutive clocks. Any single clock without it restarts the count. Once declared, the lockout holds in the hysteresis band and ends only when the above-release flag is sampled. Even then, the high side stays blocked until its command shows a fresh rising edge. A low-side power-on reset blocks both sides at once, clears the high-side timer and lockout, and leaves each side waiting for its own fresh command edge.

Top module: `supply_lockout_sup`

## Requirements
- R1: The high-side undervoltage lockout sets on the clock edge that samples the under-trip flag high for the `FILT_CYCLES`-th consecutive time. Before that edge, `hs_drv` still follows `hs_cmd`.
- R2: A single clock that samples the under-trip flag low, before the count completes, restarts the count from zero.
- R3: While locked, the lockout holds whenever the above-release flag is low, including the band where neither flag is set. It clears on the edge that samples the above-release flag high.
- R4: After any lockout, `hs_drv` stays low until a rising edge of `hs_cmd` (sampled 0, then 1) is taken at a clock edge after the release. From the following cycle on, `hs_drv` equals `hs_cmd`.
- R5: A high-side lockout has no effect on the low side: `ls_drv`, `ls_block` and `ls_rearm` keep following the low-side command and re-arm state.
- R6: While `ls_por` is high, `hs_block` and `ls_block` are 1 and `hs_drv` and `ls_drv` are 0 in the same cycle.
- R7: While `ls_por` is high, the undervoltage count and lockout are cleared. A lockout therefore needs a full new run of `FILT_CYCLES` under-trip samples after `ls_por` falls.
- R8: Lockout or power-on reset sets the re-arm flag of each affected side (`hs_rearm`, `ls_rearm` = 1). The flag clears only on a rising edge of that side's command, sampled while its own lock cause is absent.
- R9: In reset, the lockout is clear, both re-arm flags are 1, both block outputs are 1 and both drive outputs are 0.
- R10: A command held high across a release or across the end of reset is not an edge and does not re-enable its side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_below_trip | input | 1 | High-side supply is under the trip level |
| hs_above_rel | input | 1 | High-side supply is over the release level |
| ls_por | input | 1 | Low-side power-on reset active |
| hs_cmd | input | 1 | Filtered high-side drive command |
| ls_cmd | input | 1 | Filtered low-side drive command |
| hs_block | output | 1 | High-side output is blocked |
| ls_block | output | 1 | Low-side output is blocked |
| hs_rearm | output | 1 | High side waits for a fresh command edge |
| ls_rearm | output | 1 | Low side waits for a fresh command edge |
| hs_drv | output | 1 | Gated high-side drive |
| ls_drv | output | 1 | Gated low-side drive |

## Verification
The properties assume that the two high-side comparator flags are never both set, because a supply cannot be below trip and above release at once. The stimulus therefore moves between the under-trip, hysteresis-band and above-release states one flag at a time and never raises both. The properties also assume that inputs are synchronous to `clk`, so the stimulus changes them just after a rising edge. The filter is driven with runs that stop one cycle short of the threshold, and with power-on reset pulses placed in the middle of a count.

// File: rtl/sls_pkg.sv
package sls_pkg;
  localparam int NUM_SIDES = 2;
  localparam int IDX_LO    = 0;
  localparam int IDX_HI    = 1;
endpackage

// File: rtl/sls_uv_filter.sv
module sls_uv_filter #(
  parameter int FILT_CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic below,
  input  logic above,
  output logic locked,
  output logic lock_set
);
  localparam int CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;
  logic             cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    lock_d   = lock_q;
    lock_set = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (lock_q) begin
      cnt_d = '0;
      if (above && !below) lock_d = 1'b0;
    end else if (below) begin
      if (cnt_q == LAST) begin
        cnt_d    = '0;
        lock_d   = 1'b1;
        lock_set = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  assign cnt_en = clr | lock_q | below | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/sls_rearm.sv
module sls_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic force_set,
  input  logic cmd,
  output logic pending
);
  logic cmd_q;
  logic pend_q, pend_d;
  logic rise;

  assign rise = cmd & ~cmd_q;

  always_comb begin
    pend_d = pend_q;
    if (force_set)  pend_d = 1'b1;
    else if (rise)  pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b1;
      pend_q <= 1'b1;
    end else begin
      cmd_q  <= cmd;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/supply_lockout_sup.sv
module supply_lockout_sup
  import sls_pkg::*;
#(
  parameter int FILT_CYCLES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_below_trip,
  input  logic hs_above_rel,
  input  logic ls_por,
  input  logic hs_cmd,
  input  logic ls_cmd,
  output logic hs_block,
  output logic ls_block,
  output logic hs_rearm,
  output logic ls_rearm,
  output logic hs_drv,
  output logic ls_drv
);
  logic                 uv_locked;
  logic                 uv_set;
  logic [NUM_SIDES-1:0] cmd_vec;
  logic [NUM_SIDES-1:0] force_vec;
  logic [NUM_SIDES-1:0] pend_vec;
  logic [NUM_SIDES-1:0] block_vec;
  logic [NUM_SIDES-1:0] drv_vec;

  sls_uv_filter #(.FILT_CYCLES(FILT_CYCLES)) u_uv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ls_por),
    .below    (hs_below_trip),
    .above    (hs_above_rel),
    .locked   (uv_locked),
    .lock_set (uv_set)
  );

  assign cmd_vec[IDX_HI]   = hs_cmd;
  assign cmd_vec[IDX_LO]   = ls_cmd;
  assign force_vec[IDX_HI] = ls_por | uv_locked | uv_set;
  assign force_vec[IDX_LO] = ls_por;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic side_cause;
    sls_rearm u_rearm (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_set (force_vec[s]),
      .cmd       (cmd_vec[s]),
      .pending   (pend_vec[s])
    );
    if (s == IDX_HI) begin : g_hi
      assign side_cause = ls_por | uv_locked;
    end else begin : g_lo
      assign side_cause = ls_por;
    end
    assign block_vec[s] = side_cause | pend_vec[s];
    assign drv_vec[s]   = cmd_vec[s] & ~block_vec[s];
  end

  assign hs_block = block_vec[IDX_HI];
  assign ls_block = block_vec[IDX_LO];
  assign hs_rearm = pend_vec[IDX_HI];
  assign ls_rearm = pend_vec[IDX_LO];
  assign hs_drv   = drv_vec[IDX_HI];
  assign ls_drv   = drv_vec[IDX_LO];
endmodule

// File: rtl/sls_checker.sv
module sls_checker #(
  parameter int FILT_CYCLES = 800
) (
  input logic clk,
  input logic rst_n,
  input logic hs_below_trip,
  input logic hs_above_rel,
  input logic ls_por,
  input logic hs_cmd,
  input logic ls_cmd,
  input logic uv_locked,
  input logic hs_block,
  input logic ls_block,
  input logic hs_rearm,
  input logic ls_rearm,
  input logic hs_drv,
  input logic ls_drv
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else if (ls_por || !hs_below_trip) run_q <= 0;
    else if (run_q < FILT_CYCLES) run_q <= run_q + 1;
  end

  AST_UV_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_locked) |-> run_q >= FILT_CYCLES); // R1
  AST_UV_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    uv_locked && !hs_above_rel && !ls_por |=> uv_locked); // R3
  AST_UV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    uv_locked && hs_above_rel && !hs_below_trip && !ls_por |=> !uv_locked); // R3
  AST_HS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_por && !uv_locked && !hs_rearm |-> hs_drv == hs_cmd); // R4
  AST_REARM_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv_locked) |-> hs_rearm); // R8
  AST_LS_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_por && !ls_rearm |-> ls_drv == ls_cmd && !ls_block); // R5
  AST_POR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ls_por |-> hs_block && ls_block && !hs_drv && !ls_drv); // R6
  AST_POR_CLEARS_UV: assert property (@(posedge clk) disable iff (!rst_n)
    ls_por |=> !uv_locked && hs_rearm && ls_rearm); // R7
endmodule

bind supply_lockout_sup sls_checker #(.FILT_CYCLES(FILT_CYCLES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hs_below_trip (hs_below_trip),
  .hs_above_rel  (hs_above_rel),
  .ls_por        (ls_por),
  .hs_cmd        (hs_cmd),
  .ls_cmd        (ls_cmd),
  .uv_locked     (uv_locked),
  .hs_block      (hs_block),
  .ls_block      (ls_block),
  .hs_rearm      (hs_rearm),
  .ls_rearm      (ls_rearm),
  .hs_drv        (hs_drv),
  .ls_drv        (ls_drv)
);

// File: tb/supply_lockout_sup_bench.sv
module supply_lockout_sup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int F = 6;

  logic clk;
  logic rst_n;
  logic hs_below_trip, hs_above_rel, ls_por, hs_cmd, ls_cmd;
  logic hs_block, ls_block, hs_rearm, ls_rearm, hs_drv, ls_drv;

  int total;
  int bad;
  string cur_req;

  supply_lockout_sup #(.FILT_CYCLES(F)) u_supply_lockout_sup (
    .clk(clk), .rst_n(rst_n), .hs_below_trip(hs_below_trip),
    .hs_above_rel(hs_above_rel), .ls_por(ls_por), .hs_cmd(hs_cmd),
    .ls_cmd(ls_cmd), .hs_block(hs_block), .ls_block(ls_block),
    .hs_rearm(hs_rearm), .ls_rearm(ls_rearm), .hs_drv(hs_drv), .ls_drv(ls_drv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int  m_cnt;
  bit  m_lock, m_hr, m_lr, m_hq, m_lq;

  always @(posedge clk) begin
    bit hrise, lrise, was_lock, set_now;
    if (!rst_n) begin
      m_cnt = 0; m_lock = 0; m_hr = 1; m_lr = 1; m_hq = 1; m_lq = 1;
    end else begin
      hrise = hs_cmd && !m_hq;
      lrise = ls_cmd && !m_lq;
      was_lock = m_lock;
      set_now = 0;
      if (ls_por) begin
        m_cnt = 0; m_lock = 0; m_hr = 1; m_lr = 1;
      end else begin
        if (m_lock) begin
          m_cnt = 0;
          if (hs_above_rel && !hs_below_trip) m_lock = 0;
        end else if (hs_below_trip) begin
          m_cnt++;
          if (m_cnt >= F) begin m_cnt = 0; m_lock = 1; set_now = 1; end
        end else m_cnt = 0;
        if (was_lock || set_now) m_hr = 1;
        else if (hrise) m_hr = 0;
        if (lrise) m_lr = 0;
      end
      m_hq = hs_cmd;
      m_lq = ls_cmd;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit eb_h, eb_l;
      eb_h = ls_por || m_lock || m_hr;
      eb_l = ls_por || m_lr;
      chk(cur_req, "hs_block", hs_block, eb_h);
      chk(cur_req, "ls_block", ls_block, eb_l);
      chk(cur_req, "hs_rearm", hs_rearm, m_hr);
      chk(cur_req, "ls_rearm", ls_rearm, m_lr);
      chk(cur_req, "hs_drv", hs_drv, hs_cmd && !eb_h);
      chk(cur_req, "ls_drv", ls_drv, ls_cmd && !eb_l);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic at_neg;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; cur_req = "R9";
    rst_n = 1'b0;
    hs_below_trip = 1'b0; hs_above_rel = 1'b1; ls_por = 1'b0;
    hs_cmd = 1'b1; ls_cmd = 1'b1;
    tick(3);
    at_neg;
    // R9: reset state
    chk("R9", "hs_block", hs_block, 1'b1);
    chk("R9", "ls_block", ls_block, 1'b1);
    chk("R9", "hs_drv", hs_drv, 1'b0);
    chk("R9", "ls_drv", ls_drv, 1'b0);
    rst_n = 1'b1;
    // R10: commands held high across reset release do not enable
    cur_req = "R10";
    tick(3);
    at_neg;
    chk("R10", "hs_drv", hs_drv, 1'b0);
    chk("R10", "ls_drv", ls_drv, 1'b0);
    hs_cmd = 1'b0; ls_cmd = 1'b0;
    tick(1);
    // R8: fresh edges clear re-arm
    cur_req = "R8";
    hs_cmd = 1'b1; ls_cmd = 1'b1;
    tick(1);
    at_neg;
    chk("R8", "hs_drv", hs_drv, 1'b1);
    chk("R8", "ls_drv", ls_drv, 1'b1);
    // R2: interrupted runs never lock
    cur_req = "R2";
    hs_above_rel = 1'b0; hs_below_trip = 1'b1;
    tick(F-1);
    hs_below_trip = 1'b0;
    tick(1);
    hs_below_trip = 1'b1;
    tick(F-1);
    at_neg;
    chk("R2", "hs_drv", hs_drv, 1'b1);
    hs_below_trip = 1'b0;
    tick(2);
    // R1: full run locks on the F-th sample
    cur_req = "R1";
    hs_below_trip = 1'b1;
    tick(F-1);
    at_neg;
    chk("R1", "hs_drv", hs_drv, 1'b1);
    tick(1);
    at_neg;
    chk("R1", "hs_drv", hs_drv, 1'b0);
    // R5: low side keeps following its command
    cur_req = "R5";
    ls_cmd = 1'b0; tick(2);
    at_neg;
    chk("R5", "ls_drv", ls_drv, 1'b0);
    ls_cmd = 1'b1; tick(1);
    at_neg;
    chk("R5", "ls_drv", ls_drv, 1'b1);
    chk("R5", "ls_block", ls_block, 1'b0);
    // R3: hold in hysteresis band, edges ignored while locked
    cur_req = "R3";
    hs_below_trip = 1'b0;
    hs_cmd = 1'b0; tick(2);
    hs_cmd = 1'b1; tick(3);
    at_neg;
    chk("R3", "hs_block", hs_block, 1'b1);
    hs_above_rel = 1'b1;
    tick(2);
    // R10/R4: level held across release, then a fresh edge
    cur_req = "R4";
    at_neg;
    chk("R10", "hs_drv", hs_drv, 1'b0);
    hs_cmd = 1'b0; tick(1);
    hs_cmd = 1'b1; tick(1);
    at_neg;
    chk("R4", "hs_drv", hs_drv, 1'b1);
    // R6/R7: power-on reset mid-count
    cur_req = "R7";
    hs_above_rel = 1'b0; hs_below_trip = 1'b1;
    tick(3);
    ls_por = 1'b1;
    tick(1);
    at_neg;
    chk("R6", "hs_drv", hs_drv, 1'b0);
    chk("R6", "ls_drv", ls_drv, 1'b0);
    chk("R6", "ls_block", ls_block, 1'b1);
    tick(F+2);
    ls_por = 1'b0;
    tick(F-1);
    at_neg;
    chk("R7", "hs_block", hs_block, 1'b1);
    hs_below_trip = 1'b0;
    // R8: after power-on reset each side needs its own edge
    cur_req = "R8";
    tick(2);
    at_neg;
    chk("R8", "ls_drv", ls_drv, 1'b0);
    ls_cmd = 1'b0; tick(1);
    ls_cmd = 1'b1; tick(1);
    at_neg;
    chk("R8", "ls_drv", ls_drv, 1'b1);
    chk("R8", "hs_drv", hs_drv, 1'b0);
    hs_above_rel = 1'b1;
    hs_cmd = 1'b0; tick(1);
    hs_cmd = 1'b1; tick(2);
    at_neg;
    chk("R7", "hs_drv", hs_drv, 1'b1);
    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule